// File: doc/BRIEF.md
# Paired Nibble-Lane Cell Transmit Sequencer

This block is one half of a pair that feeds an 8-bit, cell-based transmit bus to a downstream device. Each half supplies one 4-bit nibble of every byte. A static mode input selects the role. The master watches the downstream cell-available input and its own count of stored cells, and decides when a cell starts. It signals the start on an active-low handshake line, which is wired to the slave's follow input. The master alone drives the transmit enable and the start-of-cell marker. The parity output takes turns between the two halves, byte by byte.

Cell storage is abstracted. A push input adds one complete cell to a bounded counter, and a start takes one away. The nibble for each byte comes from a generator: the sum of a per-instance cell sequence number and the byte index, modulo 16. Cells go out back to back when the downstream device still reports room at the sample byte and another cell is stored. Otherwise the line goes idle after the final byte.

Top module: `nib_cell_tx`

## Requirements
- R1: While reset is asserted, hs_n and xfer_en_n are 1, and soc, lane, par_oe and par are all 0.
- R2: A master that is idle, with cell_avail high and at least one stored cell, drives hs_n low in the next cycle. It never leaves idle while no cell is stored.
- R3: The master drives xfer_en_n low and byte 0 on lane in the cycle after hs_n falls. soc is 1 only on byte 0 of each cell.
- R4: Each cell holds xfer_en_n low for exactly CELL_LEN consecutive cycles. hs_n stays low on every byte except the final byte of the last cell in a burst, where it is 1.
- R5: cell_avail is sampled on byte CELL_LEN-2. If it is high and a cell is stored, byte 0 of the next cell follows the final byte with no gap, with soc at 1. Otherwise xfer_en_n returns to 1 after the final byte.
- R6: Changes of cell_avail on any byte other than CELL_LEN-2 have no effect on a transfer in progress.
- R7: In slave mode, a low lead_hs_n sampled while the slave is idle, or on its final byte, starts byte 0 in the next cycle. Otherwise a slave returns to idle after its final byte. The slave holds hs_n and xfer_en_n at 1 and soc at 0.
- R8: The master drives par_oe on even byte indices and the slave on odd ones, counting from 0 within each cell. par is the complement of the XOR of the four lane bits, so the lane bits and par together have an odd number of ones. par is 0 when par_oe is 0.
- R9: On byte k of the cell with sequence number s, lane equals (s + k) mod 16. s starts at 0 after reset and rises by one as each cell ends. lane is 0 whenever no cell is being sent.
- R10: cell_push adds one stored cell unless the store already holds CELL_CAP and no cell starts in that cycle. Each cell start removes one stored cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | 1 selects the master role, 0 the slave role |
| cell_avail | input | 1 | Downstream device can take a cell (used by the master) |
| cell_push | input | 1 | One complete cell has been stored |
| lead_hs_n | input | 1 | Master handshake, active low (used by the slave) |
| hs_n | output | 1 | Handshake to the slave, active low (master only) |
| xfer_en_n | output | 1 | Transmit enable, active low (master only) |
| soc | output | 1 | Start-of-cell marker on byte 0 (master only) |
| lane | output | NIB_W | Nibble lane data |
| par_oe | output | 1 | This side owns the parity bit on this byte |
| par | output | 1 | Parity bit value |

## Verification
The bench pairs a master with a slave and checks both against a cycle-level model. Three boundary cases matter most.

- Sample point on byte CELL_LEN-2. A design that samples one byte early or late either inserts a gap between cells or chains cells the downstream device never asked for.
- Slave alignment. If the slave starts off by one cycle relative to the handshake, its nibbles lag the master's, and the parity turns collide or leave a byte with no parity driver.
- Store boundaries. These are an empty store under a high cell_avail, and a push into a full store. A design that got them wrong would send a phantom cell or lose one.

// File: rtl/ntx_pkg.sv
package ntx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_XFER = 2'd2
  } seq_st_t;

endpackage

// File: rtl/ntx_cell_store.sv
module ntx_cell_store #(
  parameter int CELL_CAP = 4,
  localparam int CNT_W   = $clog2(CELL_CAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] cnt,
  output logic             has_cell
);

  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CELL_CAP);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             take;
  logic             put;

  always_comb begin
    take    = pop && (cnt_q != '0);
    put     = push && ((cnt_q != CAP_V) || take);
    cnt_nxt = cnt_q;
    if (take && !put)
      cnt_nxt = cnt_q - 1'b1;
    else if (put && !take)
      cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_nxt;
  end

  assign cnt      = cnt_q;
  assign has_cell = (cnt_q != '0);

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CAP_V && push && !pop) |=> (cnt_q == CAP_V));

endmodule

// File: rtl/ntx_byte_ctr.sv
module ntx_byte_ctr #(
  parameter int CELL_LEN = 53,
  localparam int BYTE_W  = $clog2(CELL_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_first,
  input  logic              step,
  output logic [BYTE_W-1:0] idx,
  output logic              at_penult,
  output logic              at_last
);

  localparam logic [BYTE_W-1:0] LAST_IDX   = BYTE_W'(CELL_LEN - 1);
  localparam logic [BYTE_W-1:0] PENULT_IDX = BYTE_W'(CELL_LEN - 2);

  logic [BYTE_W-1:0] idx_q, idx_nxt;

  always_comb begin
    idx_nxt = idx_q;
    if (ld_first)
      idx_nxt = '0;
    else if (step)
      idx_nxt = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else
      idx_q <= idx_nxt;
  end

  assign idx       = idx_q;
  assign at_penult = (idx_q == PENULT_IDX);
  assign at_last   = (idx_q == LAST_IDX);

  // R4
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_first) |=> (idx_q != '0));

endmodule

// File: rtl/ntx_lane_src.sv
module ntx_lane_src #(
  parameter int CELL_LEN = 53,
  parameter int NIB_W    = 4,
  localparam int BYTE_W  = $clog2(CELL_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              cell_done,
  input  logic              odd_side,
  input  logic [BYTE_W-1:0] idx,
  output logic [NIB_W-1:0]  nib,
  output logic              par_oe,
  output logic              par
);

  localparam logic [BYTE_W-1:0] LAST_IDX = BYTE_W'(CELL_LEN - 1);

  logic [NIB_W-1:0] seq_q, seq_nxt;
  logic [NIB_W-1:0] idx_lo;

  always_comb begin
    seq_nxt = seq_q;
    if (cell_done)
      seq_nxt = seq_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      seq_q <= '0;
    else
      seq_q <= seq_nxt;
  end

  generate
    if (BYTE_W >= NIB_W) begin : g_trunc
      assign idx_lo = idx[NIB_W-1:0];
    end else begin : g_ext
      assign idx_lo = {{(NIB_W-BYTE_W){1'b0}}, idx};
    end
  endgenerate

  always_comb begin
    nib    = active ? (seq_q + idx_lo) : '0;
    par_oe = active && (idx[0] == odd_side);
    par    = par_oe && !(^nib);
  end

  // R8
  par_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && par_oe && idx != LAST_IDX && !cell_done) |=> !par_oe);

endmodule

// File: rtl/nib_cell_tx.sv
module nib_cell_tx #(
  parameter int CELL_LEN = 53,
  parameter int CELL_CAP = 4,
  parameter int NIB_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_master,
  input  logic             cell_avail,
  input  logic             cell_push,
  input  logic             lead_hs_n,
  output logic             hs_n,
  output logic             xfer_en_n,
  output logic             soc,
  output logic [NIB_W-1:0] lane,
  output logic             par_oe,
  output logic             par
);
  import ntx_pkg::*;

  localparam int BYTE_W = $clog2(CELL_LEN);
  localparam int CNT_W  = $clog2(CELL_CAP + 1);

  seq_st_t           st_q, st_nxt;
  logic              hs_q, hs_nxt;
  logic              cont_q, cont_nxt;
  logic              ld_first, step, cell_done, active;
  logic [BYTE_W-1:0] idx;
  logic              at_penult, at_last;
  logic [CNT_W-1:0]  cnt;
  logic              has_cell;
  logic              start_ok;

  ntx_cell_store #(.CELL_CAP(CELL_CAP)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (cell_push),
    .pop      (ld_first),
    .cnt      (cnt),
    .has_cell (has_cell)
  );

  ntx_byte_ctr #(.CELL_LEN(CELL_LEN)) u_bytes (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_first  (ld_first),
    .step      (step),
    .idx       (idx),
    .at_penult (at_penult),
    .at_last   (at_last)
  );

  ntx_lane_src #(.CELL_LEN(CELL_LEN), .NIB_W(NIB_W)) u_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .cell_done (cell_done),
    .odd_side  (!is_master),
    .idx       (idx),
    .nib       (lane),
    .par_oe    (par_oe),
    .par       (par)
  );

  assign active   = (st_q == ST_XFER);
  assign start_ok = cell_avail && has_cell;

  // next-state logic
  always_comb begin
    st_nxt    = st_q;
    hs_nxt    = hs_q;
    cont_nxt  = cont_q;
    ld_first  = 1'b0;
    step      = 1'b0;
    cell_done = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (is_master) begin
          if (start_ok) begin
            st_nxt = ST_ARM;
            hs_nxt = 1'b0;
          end
        end else if (!lead_hs_n) begin
          st_nxt   = ST_XFER;
          ld_first = 1'b1;
        end
      end
      ST_ARM: begin
        st_nxt   = ST_XFER;
        ld_first = 1'b1;
      end
      ST_XFER: begin
        if (is_master && at_penult) begin
          cont_nxt = start_ok;
          hs_nxt   = !start_ok;
        end
        if (at_last) begin
          cell_done = 1'b1;
          if (is_master ? cont_q : !lead_hs_n)
            ld_first = 1'b1;
          else
            st_nxt = ST_IDLE;
        end else begin
          step = 1'b1;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hs_q   <= 1'b1;
      cont_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      hs_q   <= hs_nxt;
      cont_q <= cont_nxt;
    end
  end

  assign hs_n      = is_master ? hs_q : 1'b1;
  assign xfer_en_n = is_master ? !active : 1'b1;
  assign soc       = is_master && active && (idx == '0);

  // R2
  hs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && st_q == ST_IDLE && cell_avail && has_cell) |=> !hs_n);

  // R3
  en_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && $fell(hs_n)) |=> (!xfer_en_n && soc));

  // R4
  hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !xfer_en_n && !at_last) |-> !hs_n);

  // R5
  burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && active && at_last && !hs_n) |=> soc);

  // R7
  slave_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && (st_q == ST_IDLE || (active && at_last)) && !lead_hs_n)
      |=> (active && idx == '0));

endmodule

// File: tb/test_nib_cell_tx.sv
module test_nib_cell_tx;

  localparam int L   = 53;
  localparam int CAP = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cell_avail, cell_push;
  logic m_hs_n, m_en_n, m_soc, m_poe, m_par;
  logic s_hs_n, s_en_n, s_soc, s_poe, s_par;
  logic [3:0] m_lane, s_lane;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench reference state
  int ms, mb, mcnt, mseq, mhs, mcont;
  int sa, sb, scnt, sseq;

  always #5 clk = ~clk;

  nib_cell_tx #(.CELL_LEN(L), .CELL_CAP(CAP), .NIB_W(4)) i_nib_cell_tx (
    .clk(clk), .rst_n(rst_n), .is_master(1'b1), .cell_avail(cell_avail),
    .cell_push(cell_push), .lead_hs_n(1'b1), .hs_n(m_hs_n), .xfer_en_n(m_en_n),
    .soc(m_soc), .lane(m_lane), .par_oe(m_poe), .par(m_par)
  );

  nib_cell_tx #(.CELL_LEN(L), .CELL_CAP(CAP), .NIB_W(4)) i_nib_cell_tx_slave (
    .clk(clk), .rst_n(rst_n), .is_master(1'b0), .cell_avail(1'b0),
    .cell_push(cell_push), .lead_hs_n(m_hs_n), .hs_n(s_hs_n), .xfer_en_n(s_en_n),
    .soc(s_soc), .lane(s_lane), .par_oe(s_poe), .par(s_par)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_lane(input int act, input int seq, input int b);
    return act ? ((seq + b) % 16) : 0;
  endfunction

  function automatic int odd_par(input int nib);
    return (($countones(nib[3:0]) % 2) == 0) ? 1 : 0;
  endfunction

  function automatic int store_next(input int c, input int push, input int pop);
    int r;
    r = c - pop;
    if (push != 0 && (c < CAP || pop != 0)) r = r + 1;
    return r;
  endfunction

  task automatic model_step(input int avail, input int push);
    int nms, nmb, nmhs, nmcont, mpop, mdone;
    int nsa, nsb, spop, sdone;
    nms = ms; nmb = mb; nmhs = mhs; nmcont = mcont; mpop = 0; mdone = 0;
    case (ms)
      0: if (avail != 0 && mcnt > 0) begin nms = 1; nmhs = 0; end
      1: begin nms = 2; nmb = 0; mpop = 1; end
      default: begin
        if (mb == L - 2) begin
          nmcont = (avail != 0 && mcnt > 0) ? 1 : 0;
          nmhs = nmcont ? 0 : 1;
        end
        if (mb == L - 1) begin
          mdone = 1;
          if (mcont != 0) begin nmb = 0; mpop = 1; end
          else nms = 0;
        end else nmb = mb + 1;
      end
    endcase
    nsa = sa; nsb = sb; spop = 0; sdone = 0;
    if (sa == 0) begin
      if (mhs == 0) begin nsa = 1; nsb = 0; spop = (scnt > 0) ? 1 : 0; end
    end else if (sb == L - 1) begin
      sdone = 1;
      if (mhs == 0) begin nsb = 0; spop = (scnt > 0) ? 1 : 0; end
      else nsa = 0;
    end else nsb = sb + 1;
    mcnt = store_next(mcnt, push, mpop);
    scnt = store_next(scnt, push, spop);
    mseq = (mseq + mdone) % 16;
    sseq = (sseq + sdone) % 16;
    ms = nms; mb = nmb; mhs = nmhs; mcont = nmcont;
    sa = nsa; sb = nsb;
  endtask

  task automatic compare(input string ptag);
    int mact, ml, sl;
    mact = (ms == 2) ? 1 : 0;
    ml = exp_lane(mact, mseq, mb);
    sl = exp_lane(sa, sseq, sb);
    chk(ptag, "master hs_n", int'(m_hs_n), mhs);
    chk(ptag, "master xfer_en_n", int'(m_en_n), mact ? 0 : 1);
    chk("R3", "master soc", int'(m_soc), (mact != 0 && mb == 0) ? 1 : 0);
    chk("R9", "master lane", int'(m_lane), ml);
    chk("R8", "master par_oe", int'(m_poe), (mact != 0 && mb % 2 == 0) ? 1 : 0);
    chk("R8", "master par", int'(m_par), (mact != 0 && mb % 2 == 0) ? odd_par(ml) : 0);
    chk("R7", "slave inactive outputs", int'({s_hs_n, s_en_n, s_soc}), 6);
    chk("R7", "slave lane", int'(s_lane), sl);
    chk("R8", "slave par_oe", int'(s_poe), (sa != 0 && sb % 2 == 1) ? 1 : 0);
    chk("R8", "slave par", int'(s_par), (sa != 0 && sb % 2 == 1) ? odd_par(sl) : 0);
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input string ptag, input logic avail, input logic push);
    cell_avail = avail;
    cell_push  = push;
    @(posedge clk);
    model_step(int'(avail), int'(push));
    @(negedge clk);
    compare(ptag);
  endtask

  initial begin
    int dummy;
    dummy = $urandom(1234);
    rst_n = 1'b0; cell_avail = 1'b0; cell_push = 1'b0;
    ms = 0; mb = 0; mcnt = 0; mseq = 0; mhs = 1; mcont = 0;
    sa = 0; sb = 0; scnt = 0; sseq = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset hs_n/en_n", int'({m_hs_n, m_en_n}), 3);
    chk("R1", "reset soc/par_oe/par", int'({m_soc, m_poe, m_par}), 0);
    chk("R1", "reset lane", int'(m_lane), 0);
    chk("R1", "reset slave lane/par_oe", int'({s_lane, s_poe}), 0);
    rst_n = 1'b1;

    // R10: empty store, downstream ready: nothing may start
    for (int i = 0; i < 10; i++) cyc("R10", 1'b1, 1'b0);

    // R2: a single stored cell, single transfer
    cyc("R2", 1'b0, 1'b1);
    for (int i = 0; i < L + 10; i++) cyc("R2", 1'b1, 1'b0);

    // R5: three cells stored, back-to-back burst
    for (int i = 0; i < 3; i++) cyc("R5", 1'b0, 1'b1);
    for (int i = 0; i < 3 * L + 10; i++) cyc("R5", 1'b1, 1'b0);

    // R6: cell_avail low at the sample byte, toggled elsewhere
    for (int i = 0; i < 2; i++) cyc("R6", 1'b0, 1'b1);
    for (int i = 0; i < 2 * L + 20; i++)
      cyc("R6", (ms != 2) || (mb == L - 1) || (mb < L - 3 && (mb % 2 == 1)), 1'b0);

    // R10: overfill the store, then drain it
    for (int i = 0; i < CAP + 3; i++) cyc("R10", 1'b0, 1'b1);
    for (int i = 0; i < (CAP + 1) * L + 20; i++) cyc("R10", 1'b1, 1'b0);

    // R4: random traffic
    for (int i = 0; i < 3000; i++)
      cyc("R4", ($urandom % 4) != 0, ($urandom % 24) == 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule